// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR or low-power DDR memory from reset to the point where normal accesses can begin. After a single start pulse it first holds the memory delay line in reset for a fixed minimum time. It then drives a fixed run of commands onto a small command bus: precharge of all banks, two auto-refresh commands, a load of the base mode register, and a load of the extended mode register. When the last command has had time to settle, the block raises a done flag and leaves the bus idle.

The command bus has four parts: a set of one-hot strobes (idle, precharge, refresh, mode load), a 3-bit operation code, bank-select lines and row-address lines. The spacing after each command comes from timing inputs counted in clock cycles. These inputs are the precharge recovery time, the refresh cycle time and the mode-load recovery time. The block latches them when it accepts the start pulse, together with a one-time choice of CAS latency 3 or 4. The delay-line hold time comes from parameters giving the required hold in nanoseconds and the clock period in picoseconds.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, the bus is idle and the outputs are as follows. The idle strobe is 1 and the other strobes are 0. The code is 000, and bank and addr are 0. dl_reset, busy and done are all 0.
- R2: A start pulse accepted while idle has two effects from the next cycle on. dl_reset goes high for ceil(HOLD_NS*1000/CLK_PS) cycles, which is 25 cycles at 200 ns and 8 ns. busy goes high from that cycle on.
- R3: In the cycle after dl_reset falls, a precharge-all command is issued. The precharge strobe is 1 and the code is 001. addr has only bit 10 set (0x400), and bank is 0.
- R4: Two auto-refresh commands follow, each with code 010, addr 0 and bank 0. The first comes tRP cycles after the precharge, and the second comes tRC cycles after the first.
- R5: tRC cycles after the second refresh, the base mode register is loaded with code 011 and bank 0. addr carries the mode word. Bits 2:0 are 011 (burst length 8), bit 3 is 0 (sequential burst), and bits 6:4 hold the CAS latency. The word is 0x33 when the latched CAS select is 0 and 0x43 when it is 1.
- R6: tMRD cycles after the base load, the extended mode register is loaded with code 011, bank 2'b01 and addr 0.
- R7: tMRD cycles after the extended load, done goes to 1 and busy goes to 0. done then stays 1 until the next reset.
- R8: Exactly one of the four strobes is 1 in every cycle. Every cycle that is not a command cycle carries the idle code 000, with addr 0 and bank 0.
- R9: A timing input of value 0 gives the same spacing as the value 1.
- R10: Timing inputs and the CAS select are sampled only when a start pulse is accepted, so later changes to them have no effect. A start pulse that arrives while busy or after done is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| cas4_sel | input | 1 | 1 selects CAS latency 4, 0 selects 3 |
| t_rp | input | TW | Precharge recovery in cycles |
| t_mrd | input | TW | Mode-load recovery in cycles |
| t_rc | input | TW | Refresh cycle time in cycles |
| dl_reset | output | 1 | Delay-line reset |
| cmd_nop | output | 1 | Idle strobe |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_ref | output | 1 | Auto-refresh strobe |
| cmd_lmr | output | 1 | Mode-register load strobe |
| cmd_code | output | 3 | Operation code |
| bank | output | BANK_W | Bank-select lines |
| addr | output | ROW_W | Row-address lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, sticky |

## Verification
The sequence runs with the default spacing (3, 2, 10) under both CAS choices. It also runs with all-zero and all-maximum timing inputs and with random timing sets. Each run separates a wrong gap after a given command from a wrong command order or a wrong mode word, because every cycle of the run is compared with an expected bus state built from the latched spacing. One run changes the timing and CAS inputs and pulses start again mid-sequence, which shows whether the block resamples its inputs after start. Every run also pulses start after done, which shows whether the sequence can restart.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'b000,
    OP_PRE = 3'b001,
    OP_REF = 3'b010,
    OP_LMR = 3'b011
  } op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DLR, S_PRE, S_WPRE, S_REF1, S_WREF1, S_REF2, S_WREF2,
    S_LMR, S_WLMR, S_EMR, S_WEMR, S_DONE
  } st_t;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == CW'(1));

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |-> (cnt != '0)); // R2

endmodule

// File: rtl/ddr_init_mode.sv
module ddr_init_mode #(
  parameter int         ROW_W   = 13,
  parameter logic [2:0] BL_CODE = 3'b011
) (
  input  logic             cas4,
  output logic [ROW_W-1:0] mode_word,
  output logic [ROW_W-1:0] ext_word
);

  logic [6:0] low_bits;

  always_comb begin
    low_bits[2:0] = BL_CODE;
    low_bits[3]   = 1'b0;
    low_bits[6:4] = cas4 ? 3'd4 : 3'd3;
  end

  generate
    if (ROW_W > 7) begin : g_pad
      assign mode_word = {{(ROW_W-7){1'b0}}, low_bits};
    end else begin : g_trunc
      assign mode_word = low_bits[ROW_W-1:0];
    end
  endgenerate

  assign ext_word = '0;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int TW      = 4,
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  parameter int HOLD_NS = 200,
  parameter int CLK_PS  = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cas4_sel,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_mrd,
  input  logic [TW-1:0]     t_rc,
  output logic              dl_reset,
  output logic              cmd_nop,
  output logic              cmd_pre,
  output logic              cmd_ref,
  output logic              cmd_lmr,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  addr,
  output logic              busy,
  output logic              done
);
  import ddr_init_pkg::*;

  localparam int HOLD_RAW  = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_CLKS = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int HW        = $clog2(HOLD_CLKS + 1);
  localparam int CW        = (HW > TW) ? HW : TW;
  localparam int PALL_BIT  = 10;

  st_t           st, nxt;
  logic [TW-1:0] rp_q, mrd_q, rc_q;
  logic          cas4_q;
  logic          t_load, t_tick, t_last;
  logic [CW-1:0] t_val;
  logic [ROW_W-1:0] mode_word, ext_word;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  ddr_init_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .tick(t_tick), .last(t_last)
  );

  ddr_init_mode #(.ROW_W(ROW_W)) i_mode (
    .cas4(cas4_q), .mode_word(mode_word), .ext_word(ext_word)
  );

  // latch configuration on an accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q   <= TW'(1);
      mrd_q  <= TW'(1);
      rc_q   <= TW'(1);
      cas4_q <= 1'b0;
    end else if (st == S_IDLE && start) begin
      rp_q   <= at_least_one(t_rp);
      mrd_q  <= at_least_one(t_mrd);
      rc_q   <= at_least_one(t_rc);
      cas4_q <= cas4_sel;
    end
  end

  // next state and gap timer control
  always_comb begin
    nxt    = st;
    t_load = 1'b0;
    t_val  = '0;
    t_tick = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        nxt = S_DLR; t_load = 1'b1; t_val = CW'(HOLD_CLKS);
      end
      S_DLR: begin
        t_tick = 1'b1;
        if (t_last) nxt = S_PRE;
      end
      S_PRE: begin
        t_load = 1'b1; t_val = CW'(rp_q) - CW'(1);
        nxt = (rp_q == TW'(1)) ? S_REF1 : S_WPRE;
      end
      S_WPRE: begin
        t_tick = 1'b1;
        if (t_last) nxt = S_REF1;
      end
      S_REF1: begin
        t_load = 1'b1; t_val = CW'(rc_q) - CW'(1);
        nxt = (rc_q == TW'(1)) ? S_REF2 : S_WREF1;
      end
      S_WREF1: begin
        t_tick = 1'b1;
        if (t_last) nxt = S_REF2;
      end
      S_REF2: begin
        t_load = 1'b1; t_val = CW'(rc_q) - CW'(1);
        nxt = (rc_q == TW'(1)) ? S_LMR : S_WREF2;
      end
      S_WREF2: begin
        t_tick = 1'b1;
        if (t_last) nxt = S_LMR;
      end
      S_LMR: begin
        t_load = 1'b1; t_val = CW'(mrd_q) - CW'(1);
        nxt = (mrd_q == TW'(1)) ? S_EMR : S_WLMR;
      end
      S_WLMR: begin
        t_tick = 1'b1;
        if (t_last) nxt = S_EMR;
      end
      S_EMR: begin
        t_load = 1'b1; t_val = CW'(mrd_q) - CW'(1);
        nxt = (mrd_q == TW'(1)) ? S_DONE : S_WEMR;
      end
      S_WEMR: begin
        t_tick = 1'b1;
        if (t_last) nxt = S_DONE;
      end
      default: nxt = S_DONE;
    endcase
  end

  // output decode of the state being entered
  op_t               d_op;
  logic [BANK_W-1:0] d_bank;
  logic [ROW_W-1:0]  d_addr;

  always_comb begin
    d_op   = OP_NOP;
    d_bank = '0;
    d_addr = '0;
    case (nxt)
      S_PRE:  begin d_op = OP_PRE; d_addr[PALL_BIT] = 1'b1; end
      S_REF1, S_REF2: d_op = OP_REF;
      S_LMR:  begin d_op = OP_LMR; d_addr = mode_word; end
      S_EMR:  begin d_op = OP_LMR; d_bank = BANK_W'(1); d_addr = ext_word; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      dl_reset <= 1'b0;
      cmd_nop  <= 1'b1;
      cmd_pre  <= 1'b0;
      cmd_ref  <= 1'b0;
      cmd_lmr  <= 1'b0;
      cmd_code <= OP_NOP;
      bank     <= '0;
      addr     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      st       <= nxt;
      dl_reset <= (nxt == S_DLR);
      cmd_nop  <= (d_op == OP_NOP);
      cmd_pre  <= (d_op == OP_PRE);
      cmd_ref  <= (d_op == OP_REF);
      cmd_lmr  <= (d_op == OP_LMR);
      cmd_code <= d_op;
      bank     <= d_bank;
      addr     <= d_addr;
      busy     <= (nxt != S_IDLE) && (nxt != S_DONE);
      done     <= (nxt == S_DONE);
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_nop, cmd_pre, cmd_ref, cmd_lmr}) == 1); // R8
  AST_PRE_AFTER_DLR: assert property (@(posedge clk) disable iff (rst)
    cmd_pre |-> ($past(dl_reset) && !dl_reset)); // R3
  AST_MODE_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (cmd_lmr && bank == '0) |-> (addr[2:0] == 3'b011 && !addr[3])); // R5
  AST_EXT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_lmr && bank != '0) |-> (addr == '0)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !dl_reset)); // R10

endmodule

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;

  localparam int TW = 4;
  localparam int EXP_HOLD = 25; // 200 ns at 8 ns per clock

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cas4_sel = 1'b0;
  logic [TW-1:0] t_rp = '0, t_mrd = '0, t_rc = '0;
  logic dl_reset, cmd_nop, cmd_pre, cmd_ref, cmd_lmr, busy, done;
  logic [2:0] cmd_code;
  logic [1:0] bank;
  logic [12:0] addr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ddr_init_seq i_ddr_init_seq (
    .clk(clk), .rst(rst), .start(start), .cas4_sel(cas4_sel),
    .t_rp(t_rp), .t_mrd(t_mrd), .t_rc(t_rc),
    .dl_reset(dl_reset), .cmd_nop(cmd_nop), .cmd_pre(cmd_pre),
    .cmd_ref(cmd_ref), .cmd_lmr(cmd_lmr), .cmd_code(cmd_code),
    .bank(bank), .addr(addr), .busy(busy), .done(done)
  );

  function automatic logic [24:0] pack_exp(input logic dlr, input logic [2:0] op,
      input logic [1:0] bk, input logic [12:0] ad, input logic bz, input logic dn);
    logic [3:0] stb;
    stb = (op == 3'b001) ? 4'b0100 : (op == 3'b010) ? 4'b0010 :
          (op == 3'b011) ? 4'b0001 : 4'b1000;
    return {dlr, stb, op, bk, ad, bz, dn};
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [24:0] actual();
    return {dl_reset, cmd_nop, cmd_pre, cmd_ref, cmd_lmr, cmd_code, bank, addr, busy, done};
  endfunction

  task automatic check(input string tag, input int cyc, input logic [24:0] exp);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, actual(), exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 0, pack_exp(1'b0, 3'b000, 2'b00, 13'h0, 1'b0, 1'b0));
  endtask

  task automatic run_seq(input int rp, input int mrd, input int rc, input logic cas,
                         input bit disturb, input string extra);
    int p, r1, r2, l, e, d;
    logic [24:0] exp;
    string tag;
    do_reset();
    p  = EXP_HOLD;
    r1 = p + eff(rp);
    r2 = r1 + eff(rc);
    l  = r2 + eff(rc);
    e  = l + eff(mrd);
    d  = e + eff(mrd);
    t_rp = TW'(rp); t_mrd = TW'(mrd); t_rc = TW'(rc); cas4_sel = cas;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= d + 4; k++) begin
      if (k < p) begin exp = pack_exp(1'b1, 3'b000, 2'b00, 13'h0, 1'b1, 1'b0); tag = "R2 hold"; end
      else if (k == p) begin exp = pack_exp(1'b0, 3'b001, 2'b00, 13'h400, 1'b1, 1'b0); tag = "R3 precharge"; end
      else if (k == r1 || k == r2) begin exp = pack_exp(1'b0, 3'b010, 2'b00, 13'h0, 1'b1, 1'b0); tag = "R4 refresh"; end
      else if (k == l) begin exp = pack_exp(1'b0, 3'b011, 2'b00, cas ? 13'h43 : 13'h33, 1'b1, 1'b0); tag = "R5 mode load"; end
      else if (k == e) begin exp = pack_exp(1'b0, 3'b011, 2'b01, 13'h0, 1'b1, 1'b0); tag = "R6 ext load"; end
      else if (k >= d) begin exp = pack_exp(1'b0, 3'b000, 2'b00, 13'h0, 1'b0, 1'b1); tag = "R7 done"; end
      else begin exp = pack_exp(1'b0, 3'b000, 2'b00, 13'h0, 1'b1, 1'b0); tag = "R8 nop gap"; end
      check({extra, tag}, k, exp);
      if (disturb && k == 3) begin
        start = 1'b1; cas4_sel = ~cas;
        t_rp = TW'(rp + 5); t_mrd = TW'(mrd + 3); t_rc = TW'(rc + 2);
      end else if (disturb && k == p + 1) begin
        start = 1'b1;
      end else if (k == d + 1) begin
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_void;
    seed_void = $urandom(32'h5eed);
    run_seq(3, 2, 10, 1'b0, 1'b0, "");
    run_seq(3, 2, 10, 1'b1, 1'b0, "");
    run_seq(0, 0, 0, 1'b0, 1'b0, "R9 ");
    run_seq(1, 1, 1, 1'b1, 1'b0, "R9 ");
    run_seq(15, 15, 15, 1'b1, 1'b0, "");
    run_seq(4, 3, 6, 1'b0, 1'b1, "R10 ");
    for (int i = 0; i < 8; i++) begin
      run_seq(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'b0, "");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule